// File: doc/BRIEF.md
# CAN Controller Command and Interrupt Register Block

This block is the host-facing control slice of a CAN controller. A host bus writes a command byte that starts, aborts or retires transmissions, releases the receive buffer and clears the overrun indication. The host reads a status byte, a pending-interrupt byte, an interrupt-enable byte and two capture registers. These hold the bit position where arbitration was lost and the code of the last bus error. The protocol core drives event inputs and level inputs. The block turns them into sticky flags and drives one combined interrupt line.

Toward the core the block drives a transmit request with two qualifiers: single-shot (no automatic retry) and self-reception. It also drives a one-cycle receive-buffer release pulse and a prescaler doubling control. Reads on the host bus have side effects that act at the clock edge where the read is strobed. Read data is combinational from the address and the current state.

Register map on `host_addr`: 0 mode (bit0 = reset mode), 1 command (write only, reads 0), 2 status, 3 pending interrupts, 4 interrupt enable, 5 arbitration-lost position, 6 error code.

Top module: `can_cmdirq_regs`

## Requirements
- R1: After reset the mode register reads 1 (reset mode) and status reads 0x04 (buffer free). The interrupt and enable registers read 0, and `irq`, `tx_req` and `presc_x2` are 0.
- R2: The command register always reads 0. Writing command bit2 makes `rx_release` high for exactly the one cycle after the write edge.
- R3: Writing command bit0 outside reset mode while the buffer is free asserts `tx_req`, clears `tx_single` and `tx_self`, and clears status bit2 (buffer free) and bit3 (transmit complete). Transmit commands are ignored in reset mode and while a request is pending.
- R4: Command 0x03 (bit0 with abort bit1) requests a single-shot transmit. Command 0x10 (bit4) requests a self-reception transmit with retry. Command 0x12 requests a single-shot self-reception transmit.
- R5: A transmit-success event drops `tx_req` and sets status bits 2 and 3 and interrupt bit1. A transmit-error event leaves a retrying request pending. For a single-shot request it drops `tx_req`, sets status bit2 with bit3 at 0, and sets interrupt bit1.
- R6: Abort alone (0x02) cancels a pending request not yet on the bus. It sets status bits 2 and 3 and interrupt bit1. While `tx_on_bus` is 1 it has no effect.
- R7: An overrun event sets status bit1; command bit3 clears it.
- R8: A read of the interrupt register clears interrupt bits 1, 2, 5, 6 and 7 at that edge. Bit0 follows `rx_pending` and is not cleared by the read. Bits 3 and 4 read 0.
- R9: Any change of `err_status` or `bus_off` sets interrupt bit2. An error-passive event sets interrupt bit5.
- R10: An arbitration-lost event while armed stores `arb_pos` in register 5, sets interrupt bit6 and disarms. Later events are ignored until register 5 is read, which rearms.
- R11: A bus-error event while armed stores `err_code` in register 6, sets interrupt bit7 and disarms. A read of register 6 rearms.
- R12: The enable register takes writes only in reset mode. Its bit4 drives `presc_x2` and never enables an interrupt.
- R13: `irq` is high exactly when some interrupt bit in {0,1,2,5,6,7} is pending with its enable bit set.
- R14: A rising edge of `bus_off` forces the mode register back to reset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational) |
| rx_pending | input | 1 | Unread frames remain in receive storage |
| rx_on_bus | input | 1 | Core is receiving |
| tx_on_bus | input | 1 | Core is transmitting the pending frame |
| ev_tx_ok | input | 1 | Transmit finished successfully (pulse) |
| ev_tx_err | input | 1 | Transmit attempt failed (pulse) |
| ev_overrun | input | 1 | Receive storage overran (pulse) |
| err_status | input | 1 | Error counter at or above warning limit |
| bus_off | input | 1 | Core is bus-off |
| ev_err_passive | input | 1 | Error-passive transition (pulse) |
| ev_arb_lost | input | 1 | Arbitration lost (pulse) |
| arb_pos | input | 5 | Bit position where arbitration was lost |
| ev_bus_err | input | 1 | Bus error detected (pulse) |
| err_code | input | 8 | Encoded bus error description |
| tx_req | output | 1 | Frame waiting for or in transmission |
| tx_single | output | 1 | Pending frame is single-shot |
| tx_self | output | 1 | Pending frame uses self-reception |
| rx_release | output | 1 | Receive buffer release pulse |
| presc_x2 | output | 1 | Prescaler doubling control |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the overlaps between command encodings. A design that treats 0x03 as an abort would never raise `tx_req`. One that forgets the qualifier would retry a single-shot frame forever after an error. The abort-while-on-bus case catches a design that drops a frame already being sent. Read-to-clear is checked with `rx_pending` held high: a design that clears bit0 would lose pending frames, and one that clears nothing would leave `irq` stuck. The capture tests fire a second event before the rearming read. A design that overwrote the capture, or rearmed on an interrupt read, would report the wrong position.

// File: rtl/canreg_pkg.sv
package canreg_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE = 3'd0,
    A_CMD  = 3'd1,
    A_STAT = 3'd2,
    A_INT  = 3'd3,
    A_IEN  = 3'd4,
    A_ALC  = 3'd5,
    A_ECC  = 3'd6
  } reg_addr_e;

  // interrupt bit positions
  localparam int INT_RX = 0;
  localparam int INT_TX = 1;
  localparam int INT_EW = 2;
  localparam int INT_EP = 5;
  localparam int INT_AL = 6;
  localparam int INT_BE = 7;
  localparam int IEN_PRESC = 4;

  localparam logic [REG_W-1:0] INT_IMPL_MASK = 8'hE7;
  localparam logic [REG_W-1:0] INT_READ_CLR  = 8'hE6;

  typedef struct packed {
    logic self_rx;
    logic clr_ovr;
    logic rel_rx;
    logic abort;
    logic tx;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [REG_W-1:0] w);
    cmd_t c;
    c.tx      = w[0];
    c.abort   = w[1];
    c.rel_rx  = w[2];
    c.clr_ovr = w[3];
    c.self_rx = w[4];
    return c;
  endfunction

  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return (q & ~clr) | set;
  endfunction

  function automatic logic irq_reduce(input logic [REG_W-1:0] flags,
                                      input logic [REG_W-1:0] en);
    return |(flags & en & INT_IMPL_MASK);
  endfunction

endpackage

// File: rtl/canreg_cmdexec.sv
module canreg_cmdexec
  import canreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reset_mode,
  input  logic cmd_wr,
  input  cmd_t cmd,
  input  logic tx_on_bus,
  input  logic ev_tx_ok,
  input  logic ev_tx_err,
  input  logic ev_overrun,
  output logic tx_req_o,
  output logic tx_single_o,
  output logic tx_self_o,
  output logic tbs_o,
  output logic tcs_o,
  output logic dos_o,
  output logic rx_release_o,
  output logic tx_irq_set_o
);

  logic req_cmd, accept_req, abort_only, abort_cancel, ok_finish, fail_finish;

  assign tbs_o        = ~tx_req_o;
  assign req_cmd      = cmd_wr & (cmd.tx | cmd.self_rx);
  assign accept_req   = req_cmd & ~reset_mode & tbs_o;
  assign abort_only   = cmd_wr & cmd.abort & ~(cmd.tx | cmd.self_rx);
  assign abort_cancel = abort_only & tx_req_o & ~tx_on_bus;
  assign ok_finish    = tx_req_o & ev_tx_ok;
  assign fail_finish  = tx_req_o & ev_tx_err & tx_single_o;
  assign tx_irq_set_o = ok_finish | fail_finish | abort_cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_req_o    <= 1'b0;
      tx_single_o <= 1'b0;
      tx_self_o   <= 1'b0;
      tcs_o       <= 1'b0;
    end else if (accept_req) begin
      tx_req_o    <= 1'b1;
      tx_single_o <= cmd.abort;
      tx_self_o   <= cmd.self_rx;
      tcs_o       <= 1'b0;
    end else if (ok_finish) begin
      tx_req_o <= 1'b0;
      tcs_o    <= 1'b1;
    end else if (fail_finish) begin
      tx_req_o <= 1'b0;
      tcs_o    <= 1'b0;
    end else if (abort_cancel) begin
      tx_req_o <= 1'b0;
      tcs_o    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dos_o        <= 1'b0;
      rx_release_o <= 1'b0;
    end else begin
      dos_o        <= flag_next(dos_o, ev_overrun, cmd_wr & cmd.clr_ovr);
      rx_release_o <= cmd_wr & cmd.rel_rx;
    end
  end

  // R5
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o && ev_tx_err && !tx_single_o && !ev_tx_ok && !abort_cancel |=> tx_req_o);

  // R6
  onbus_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_only && tx_req_o && tx_on_bus && !ev_tx_ok && !ev_tx_err |=> tx_req_o);

  // R3
  locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_cmd && tx_req_o |=> $stable(tx_single_o) && $stable(tx_self_o));

  // R2
  release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_release_o |=> !rx_release_o || $past(cmd_wr && cmd.rel_rx));

endmodule

// File: rtl/canreg_capture.sv
module canreg_capture #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic [W-1:0] ev_val,
  input  logic         rd_ack,
  output logic [W-1:0] value_o,
  output logic         armed_o,
  output logic         captured_o
);

  assign captured_o = ev & armed_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_o <= '0;
      armed_o <= 1'b1;
    end else begin
      if (captured_o) begin
        value_o <= ev_val;
        armed_o <= 1'b0;
      end
      if (rd_ack) armed_o <= 1'b1;
    end
  end

  // R10, R11
  hold_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_o && !rd_ack |=> $stable(value_o) && !armed_o);

endmodule

// File: rtl/canreg_irq.sv
module canreg_irq
  import canreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_mode,
  input  logic             ien_wr,
  input  logic [REG_W-1:0] ien_wdata,
  input  logic             int_rd,
  input  logic [REG_W-1:0] set_i,
  input  logic             rx_pending,
  output logic [REG_W-1:0] flags_o,
  output logic [REG_W-1:0] ien_o,
  output logic             presc_x2_o,
  output logic             irq_o
);

  logic [REG_W-1:0] flag_q;

  for (genvar b = 0; b < REG_W; b++) begin : g_flag
    if (b != INT_RX && INT_IMPL_MASK[b]) begin : g_live
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= flag_next(q, set_i[b], int_rd & INT_READ_CLR[b]);
      end
      assign flag_q[b] = q;
    end else begin : g_tied
      assign flag_q[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ien_o <= '0;
    else if (ien_wr && reset_mode) ien_o <= ien_wdata;
  end

  assign flags_o    = flag_q | {{(REG_W-1){1'b0}}, rx_pending};
  assign presc_x2_o = ien_o[IEN_PRESC];
  assign irq_o      = irq_reduce(flags_o, ien_o);

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd && (set_i == '0) |=> (flag_q & INT_READ_CLR) == '0);

  // R12
  ien_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien_wr && !reset_mode |=> $stable(ien_o));

  // R13
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_o & INT_IMPL_MASK) == '0 |-> !irq_o);

endmodule

// File: rtl/can_cmdirq_regs.sv
module can_cmdirq_regs
  import canreg_pkg::*;
#(
  parameter int ALC_W = 5,
  parameter int ECC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic              rx_pending,
  input  logic              rx_on_bus,
  input  logic              tx_on_bus,
  input  logic              ev_tx_ok,
  input  logic              ev_tx_err,
  input  logic              ev_overrun,
  input  logic              err_status,
  input  logic              bus_off,
  input  logic              ev_err_passive,
  input  logic              ev_arb_lost,
  input  logic [ALC_W-1:0]  arb_pos,
  input  logic              ev_bus_err,
  input  logic [ECC_W-1:0]  err_code,
  output logic              tx_req,
  output logic              tx_single,
  output logic              tx_self,
  output logic              rx_release,
  output logic              presc_x2,
  output logic              irq
);

  logic wr_hit, rd_hit;
  logic cmd_wr, mode_wr, ien_wr, int_rd, alc_rd, ecc_rd;
  logic reset_mode_q, es_prev, bo_prev, bo_rise, ew_change;
  logic tbs, tcs, dos, tx_irq_set;
  logic al_cap, be_cap, al_armed, be_armed;
  logic [ALC_W-1:0] alc_val;
  logic [ECC_W-1:0] ecc_val;
  logic [REG_W-1:0] set_vec, flags, ien, status;
  cmd_t cmd;

  assign wr_hit  = host_sel & host_wr;
  assign rd_hit  = host_sel & ~host_wr;
  assign cmd_wr  = wr_hit & (host_addr == A_CMD);
  assign mode_wr = wr_hit & (host_addr == A_MODE);
  assign ien_wr  = wr_hit & (host_addr == A_IEN);
  assign int_rd  = rd_hit & (host_addr == A_INT);
  assign alc_rd  = rd_hit & (host_addr == A_ALC);
  assign ecc_rd  = rd_hit & (host_addr == A_ECC);
  assign cmd     = decode_cmd(host_wdata);

  assign bo_rise   = bus_off & ~bo_prev;
  assign ew_change = (err_status != es_prev) | (bus_off != bo_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_mode_q <= 1'b1;
      es_prev      <= 1'b0;
      bo_prev      <= 1'b0;
    end else begin
      es_prev <= err_status;
      bo_prev <= bus_off;
      if (bo_rise)      reset_mode_q <= 1'b1;
      else if (mode_wr) reset_mode_q <= host_wdata[0];
    end
  end

  canreg_cmdexec u_cmd (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode_q),
    .cmd_wr(cmd_wr), .cmd(cmd), .tx_on_bus(tx_on_bus),
    .ev_tx_ok(ev_tx_ok), .ev_tx_err(ev_tx_err), .ev_overrun(ev_overrun),
    .tx_req_o(tx_req), .tx_single_o(tx_single), .tx_self_o(tx_self),
    .tbs_o(tbs), .tcs_o(tcs), .dos_o(dos), .rx_release_o(rx_release),
    .tx_irq_set_o(tx_irq_set)
  );

  canreg_capture #(.W(ALC_W)) u_alc (
    .clk(clk), .rst_n(rst_n), .ev(ev_arb_lost), .ev_val(arb_pos),
    .rd_ack(alc_rd), .value_o(alc_val), .armed_o(al_armed), .captured_o(al_cap)
  );

  canreg_capture #(.W(ECC_W)) u_ecc (
    .clk(clk), .rst_n(rst_n), .ev(ev_bus_err), .ev_val(err_code),
    .rd_ack(ecc_rd), .value_o(ecc_val), .armed_o(be_armed), .captured_o(be_cap)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[INT_TX] = tx_irq_set;
    set_vec[INT_EW] = ew_change;
    set_vec[INT_EP] = ev_err_passive;
    set_vec[INT_AL] = al_cap;
    set_vec[INT_BE] = be_cap;
  end

  canreg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode_q),
    .ien_wr(ien_wr), .ien_wdata(host_wdata), .int_rd(int_rd),
    .set_i(set_vec), .rx_pending(rx_pending), .flags_o(flags),
    .ien_o(ien), .presc_x2_o(presc_x2), .irq_o(irq)
  );

  assign status = {bus_off, err_status, tx_on_bus, rx_on_bus, tcs, tbs, dos, rx_pending};

  always_comb begin
    case (host_addr)
      A_MODE:  host_rdata = {{(REG_W-1){1'b0}}, reset_mode_q};
      A_STAT:  host_rdata = status;
      A_INT:   host_rdata = flags;
      A_IEN:   host_rdata = ien;
      A_ALC:   host_rdata = REG_W'(alc_val);
      A_ECC:   host_rdata = REG_W'(ecc_val);
      default: host_rdata = '0;
    endcase
  end

  // R14
  busoff_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bo_rise |=> reset_mode_q);

  // R3
  reset_mode_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode_q && !tx_req |=> !tx_req);

endmodule

// File: tb/can_cmdirq_regs_bench.sv
module can_cmdirq_regs_bench;
  import canreg_pkg::*;

  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_sel = 0, host_wr = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic rx_pending = 0, rx_on_bus = 0, tx_on_bus = 0, ev_tx_ok = 0, ev_tx_err = 0;
  logic ev_overrun = 0, err_status = 0, bus_off = 0, ev_err_passive = 0;
  logic ev_arb_lost = 0, ev_bus_err = 0;
  logic [4:0] arb_pos = 0;
  logic [7:0] err_code = 0;
  logic tx_req, tx_single, tx_self, rx_release, presc_x2, irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  can_cmdirq_regs u_can_cmdirq_regs (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_pending(rx_pending), .rx_on_bus(rx_on_bus), .tx_on_bus(tx_on_bus),
    .ev_tx_ok(ev_tx_ok), .ev_tx_err(ev_tx_err), .ev_overrun(ev_overrun),
    .err_status(err_status), .bus_off(bus_off), .ev_err_passive(ev_err_passive),
    .ev_arb_lost(ev_arb_lost), .arb_pos(arb_pos), .ev_bus_err(ev_bus_err),
    .err_code(err_code), .tx_req(tx_req), .tx_single(tx_single), .tx_self(tx_self),
    .rx_release(rx_release), .presc_x2(presc_x2), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    step();
    host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_sel = 1; host_wr = 0; host_addr = a;
    #1 d = host_rdata;
    step();
    host_sel = 0;
  endtask

  function automatic logic model_irq(input logic [7:0] fl, input logic [7:0] en);
    logic acc = 1'b0;
    for (int b = 0; b < 8; b++)
      if (b != 3 && b != 4) acc = acc | (fl[b] & en[b]);
    return acc;
  endfunction

  task automatic pulse_ok();  ev_tx_ok = 1;  step(); ev_tx_ok = 0;  endtask
  task automatic pulse_err(); ev_tx_err = 1; step(); ev_tx_err = 0; endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp_q, ien_m;
    logic es_m, rxp_m, rd_m, ep_m, es_n;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step();

    // R1 reset state
    rd(A_MODE, d); chk("R1 mode", d, 8'h01);
    rd(A_STAT, d); chk("R1 status", d, 8'h04);
    rd(A_INT, d);  chk("R1 int", d, 8'h00);
    rd(A_IEN, d);  chk("R1 ien", d, 8'h00);
    chk("R1 outputs", {irq, tx_req, presc_x2}, 3'b000);

    // R12 enable writable in reset mode, bit4 prescaler
    wr(A_IEN, 8'hF7);
    rd(A_IEN, d); chk("R12 ien write", d, 8'hF7);
    chk("R12 presc_x2", presc_x2, 1'b1);
    chk("R12 bit4 no irq", irq, 1'b0);

    // R3 tx ignored in reset mode
    wr(A_CMD, 8'h01); chk("R3 reset-mode ignore", tx_req, 1'b0);

    wr(A_MODE, 8'h00);
    wr(A_IEN, 8'h00);
    rd(A_IEN, d); chk("R12 locked outside reset", d, 8'hF7);

    // R3 normal request
    wr(A_CMD, 8'h01);
    chk("R3 tx_req", {tx_req, tx_single, tx_self}, 3'b100);
    rd(A_STAT, d); chk("R3 status locked", d, 8'h00);
    rd(A_CMD, d);  chk("R2 cmd reads 0", d, 8'h00);
    wr(A_CMD, 8'h03);
    chk("R3 locked ignore", {tx_req, tx_single}, 2'b10);

    // R5 retry then success
    pulse_err(); chk("R5 retry keeps req", tx_req, 1'b1);
    pulse_ok();  chk("R5 ok drops req", tx_req, 1'b0);
    rd(A_STAT, d); chk("R5 ok status", d, 8'h0C);
    chk("R13 irq on tx", irq, 1'b1);
    rd(A_INT, d); chk("R5 tx flag", d & 8'h02, 8'h02);
    rd(A_INT, d); chk("R8 read cleared", d, 8'h00);
    chk("R13 irq cleared", irq, 1'b0);

    // R4 / R5 single shot
    wr(A_CMD, 8'h03);
    chk("R4 single", {tx_req, tx_single, tx_self}, 3'b110);
    rd(A_STAT, d); chk("R3 tcs cleared", d, 8'h00);
    pulse_err();
    chk("R5 single err drop", tx_req, 1'b0);
    rd(A_STAT, d); chk("R5 single err status", d, 8'h04);
    rd(A_INT, d); chk("R5 single err flag", d & 8'h02, 8'h02);

    wr(A_CMD, 8'h12);
    chk("R4 self single", {tx_req, tx_single, tx_self}, 3'b111);
    pulse_ok();
    wr(A_CMD, 8'h10);
    chk("R4 self retry", {tx_req, tx_single, tx_self}, 3'b101);
    pulse_ok();

    // R6 abort
    wr(A_CMD, 8'h01);
    tx_on_bus = 1;
    wr(A_CMD, 8'h02); chk("R6 on-bus abort ignored", tx_req, 1'b1);
    tx_on_bus = 0;
    rd(A_INT, d);
    wr(A_CMD, 8'h02); chk("R6 abort cancels", tx_req, 1'b0);
    rd(A_STAT, d); chk("R6 abort status", d, 8'h0C);
    rd(A_INT, d);  chk("R6 abort flag", d & 8'h02, 8'h02);

    // R2 release pulse
    wr(A_CMD, 8'h04); chk("R2 release high", rx_release, 1'b1);
    step();           chk("R2 release one cycle", rx_release, 1'b0);

    // R7 overrun
    ev_overrun = 1; step(); ev_overrun = 0;
    rd(A_STAT, d); chk("R7 overrun set", d & 8'h02, 8'h02);
    wr(A_CMD, 8'h08);
    rd(A_STAT, d); chk("R7 overrun cleared", d & 8'h02, 8'h00);

    // R10 arbitration-lost capture
    rd(A_INT, d);
    ev_arb_lost = 1; arb_pos = 5'd5; step(); ev_arb_lost = 0;
    rd(A_INT, d); chk("R10 al flag", d & 8'h40, 8'h40);
    ev_arb_lost = 1; arb_pos = 5'd9; step(); ev_arb_lost = 0;
    rd(A_INT, d); chk("R10 disarmed no flag", d & 8'h40, 8'h00);
    rd(A_ALC, d); chk("R10 first kept", d, 8'd5);
    ev_arb_lost = 1; arb_pos = 5'd12; step(); ev_arb_lost = 0;
    rd(A_ALC, d); chk("R10 rearmed capture", d, 8'd12);

    // R11 bus-error capture
    rd(A_INT, d);
    ev_bus_err = 1; err_code = 8'hA3; step(); ev_bus_err = 0;
    rd(A_INT, d); chk("R11 be flag", d & 8'h80, 8'h80);
    ev_bus_err = 1; err_code = 8'h3C; step(); ev_bus_err = 0;
    rd(A_ECC, d); chk("R11 first kept", d, 8'hA3);
    ev_bus_err = 1; err_code = 8'h3C; step(); ev_bus_err = 0;
    rd(A_ECC, d); chk("R11 rearmed capture", d, 8'h3C);

    // R9 error warning / passive
    rd(A_INT, d);
    err_status = 1; step();
    rd(A_INT, d); chk("R9 ew on change", d, 8'h04);
    ev_err_passive = 1; step(); ev_err_passive = 0;
    rd(A_INT, d); chk("R9 ep flag", d, 8'h20);
    err_status = 0; step(); rd(A_INT, d);

    // R8 receive bit not cleared by read
    rx_pending = 1; #1;
    chk("R13 irq on rx", irq, 1'b1);
    rd(A_INT, d); chk("R8 rx bit", d, 8'h01);
    rd(A_INT, d); chk("R8 rx survives read", d, 8'h01);
    rx_pending = 0;

    // R13 masking
    wr(A_MODE, 8'h01); wr(A_IEN, 8'h01); wr(A_MODE, 8'h00);
    chk("R12 presc off", presc_x2, 1'b0);
    ev_err_passive = 1; step(); ev_err_passive = 0;
    chk("R13 masked flag no irq", irq, 1'b0);
    rd(A_INT, d); chk("R13 flag pending", d, 8'h20);

    // R14 bus-off forces reset mode
    bus_off = 1; step();
    rd(A_MODE, d); chk("R14 bus-off reset mode", d, 8'h01);
    bus_off = 0; step();

    // random segment on flags and irq
    wr(A_IEN, 8'h25); wr(A_MODE, 8'h00);
    rd(A_INT, d);
    exp_q = 8'h00; ien_m = 8'h25; es_m = 0; rxp_m = 0;
    for (int i = 0; i < 400; i++) begin
      es_n  = (($urandom % 4) == 0) ? ~es_m : es_m;
      ep_m  = (($urandom % 5) == 0);
      rd_m  = (($urandom % 3) == 0);
      if (($urandom % 3) == 0) rxp_m = ~rxp_m;
      err_status = es_n; ev_err_passive = ep_m; rx_pending = rxp_m;
      host_sel = rd_m; host_wr = 0; host_addr = A_INT;
      #1;
      chk("R13 random irq", irq, model_irq(exp_q | {7'b0, rxp_m}, ien_m));
      if (rd_m) chk("R8 random read", host_rdata, exp_q | {7'b0, rxp_m});
      step();
      exp_q = (rd_m ? (exp_q & 8'h19) : exp_q)
            | ((es_n != es_m) ? 8'h04 : 8'h00) | (ep_m ? 8'h20 : 8'h00);
      es_m = es_n;
    end
    host_sel = 0; ev_err_passive = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule